// File: doc/BRIEF.md
# Watch-Mode Low-Power Controller

This controller moves a small processor subsystem between a sub-clock run state and a deep watch state. In the watch state the CPU and peripheral clocks are gated off, and only the sub-clock and the watch-timer enable stay alive. Memory and register contents are retained, because no reset is applied to them. Software requests the watch state by writing the run bit low through a single configuration write strobe. That write also carries a float bit, which chooses whether external pins freeze at their last level or go to high impedance while the subsystem sleeps.

There are two ways out of the watch state. An enabled interrupt returns the subsystem straight to sub-clock run and emits a one-cycle wake strobe to the CPU. A reset request instead passes through an oscillation-stabilization wait of `WAIT_LEN` cycles, which is further extended while `osc_ok` is low. It then enters a one-cycle reset-sequence state and returns to run. External bus hold requests are acknowledged only in the run state.

Top module: `wmode_ctrl`

## Requirements
- R1: After reset the controller is in run (state 4'b0001) with `run_bit` = 1, CPU, peripheral and watch-timer enables high, and the pin, hold and wake outputs low.
- R2: A write with `cfg_run` = 0, while `on_subclk` = 1 and no enabled interrupt is pending, enters the watch state (4'b0010) on the next edge. In the watch state the CPU and peripheral enables are low and `wtmr_en` is high. A write with `cfg_run` = 1 stays in run.
- R3: A write with `cfg_run` = 0 while `on_subclk` = 0 leaves the controller in run.
- R4: An enabled interrupt (`irq_req` = 1 with `irq_lvl` not 3'b111) present during the request write blocks entry, and the controller stays in run.
- R5: `cfg_float` is captured by the entering write. While in watch, a captured 1 drives `pin_hiz` high and a captured 0 drives `pin_freeze` high. Outside watch, both are low.
- R6: `hold_ack` equals `hold_req` in run and is low in every other state.
- R7: In watch, an enabled interrupt returns the controller to run on the next edge. In that cycle `wake_stb` is high for exactly one cycle and `run_bit` reads 1.
- R8: In watch, an interrupt with `irq_lvl` = 3'b111 is ignored, and the controller stays in watch.
- R9: A reset request in watch moves to the oscillator-wait state (4'b0100). The reset-sequence state (4'b1000) follows exactly `WAIT_LEN` edges later, then run with `run_bit` = 1.
- R10: While `osc_ok` is low, the oscillator wait does not end even after the count has expired.
- R11: A reset request and an enabled interrupt in the same watch cycle lead to the oscillator-wait state, with no wake strobe.
- R12: A reset request in run moves directly to the reset-sequence state on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Written run bit; 0 requests the watch state |
| cfg_float | input | 1 | Written pin choice; 1 floats the pins in watch |
| on_subclk | input | 1 | High when the sub-clock drives the system |
| irq_req | input | 1 | Pending interrupt request |
| irq_lvl | input | 3 | Interrupt level; 3'b111 means disabled |
| rst_req | input | 1 | Reset request |
| hold_req | input | 1 | External bus hold request |
| osc_ok | input | 1 | Oscillator stable indication |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wtmr_en | output | 1 | Watch-timer clock enable |
| pin_hiz | output | 1 | Drive external pins to high impedance |
| pin_freeze | output | 1 | Hold external pins at their last level |
| hold_ack | output | 1 | Bus hold acknowledge |
| wake_stb | output | 1 | One-cycle interrupt wake pulse |
| run_bit | output | 1 | Read-back of the run bit |
| state | output | 4 | One-hot state: run, watch, osc wait, reset sequence |

## Verification
Every state change, the wake strobe and the run-bit read-back appear one rising edge after the inputs that cause them. `hold_ack` is combinational from `hold_req` and the current state, so it is visible in the same cycle. The bench changes inputs on the falling edge, waits for one rising edge, and compares the whole output bundle on the next falling edge. For the oscillator wait, it counts rising edges from the entry into that state and expects the reset-sequence state on exactly the `WAIT_LEN`-th edge.

// File: rtl/wmode_ctrl.sv
module wmode_ctrl #(
  parameter int WAIT_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_run,
  input  logic       cfg_float,
  input  logic       on_subclk,
  input  logic       irq_req,
  input  logic [2:0] irq_lvl,
  input  logic       rst_req,
  input  logic       hold_req,
  input  logic       osc_ok,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       wtmr_en,
  output logic       pin_hiz,
  output logic       pin_freeze,
  output logic       hold_ack,
  output logic       wake_stb,
  output logic       run_bit,
  output logic [3:0] state
);
  localparam int CW = $clog2(WAIT_LEN + 1);

  typedef enum logic [3:0] {
    S_RUN   = 4'b0001,
    S_WATCH = 4'b0010,
    S_OSC   = 4'b0100,
    S_RSEQ  = 4'b1000
  } st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt;
  logic          run_q, float_q, wake_q;

  wire irq_live = irq_req & (irq_lvl != 3'b111);
  wire enter    = cfg_wr & ~cfg_run & on_subclk & ~irq_live;
  wire woken    = (st == S_WATCH) & ~rst_req & irq_live;

  always_comb begin
    nxt = st;
    case (st)
      S_RUN:   if (rst_req) nxt = S_RSEQ;
               else if (enter) nxt = S_WATCH;
      S_WATCH: if (rst_req) nxt = S_OSC;
               else if (irq_live) nxt = S_RUN;
      S_OSC:   if (cnt == '0 && osc_ok) nxt = S_RSEQ;
      S_RSEQ:  nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      cnt     <= CW'(WAIT_LEN - 1);
      run_q   <= 1'b1;
      float_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      st     <= nxt;
      wake_q <= woken;
      if (st != S_OSC)
        cnt <= CW'(WAIT_LEN - 1);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
      if (st == S_RSEQ || woken)
        run_q <= 1'b1;
      else if (st == S_RUN && cfg_wr)
        run_q <= cfg_run;
      if (st == S_RUN && enter && !rst_req)
        float_q <= cfg_float;
    end
  end

  assign state      = st;
  assign cpu_clk_en = (st == S_RUN) | (st == S_RSEQ);
  assign per_clk_en = cpu_clk_en;
  assign wtmr_en    = (st == S_RUN) | (st == S_WATCH);
  assign pin_hiz    = (st == S_WATCH) & float_q;
  assign pin_freeze = (st == S_WATCH) & ~float_q;
  assign hold_ack   = (st == S_RUN) & hold_req;
  assign wake_stb   = wake_q;
  assign run_bit    = run_q;
endmodule

// File: rtl/wmode_chk.sv
module wmode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       cfg_run,
  input logic       on_subclk,
  input logic       irq_req,
  input logic [2:0] irq_lvl,
  input logic       rst_req,
  input logic       osc_ok,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       wtmr_en,
  input logic       pin_hiz,
  input logic       pin_freeze,
  input logic       hold_ack,
  input logic       wake_stb,
  input logic       run_bit,
  input logic [3:0] state
);
  wire live = irq_req & (irq_lvl != 3'b111);

  AST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    state[0] && cfg_wr && !cfg_run && on_subclk && !live && !rst_req |=> state[1]); // R2
  AST_WATCH_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    state[1] |-> !cpu_clk_en && !per_clk_en && wtmr_en); // R2
  AST_MAINCLK_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    state[0] && cfg_wr && !on_subclk && !rst_req |=> state[0]); // R3
  AST_IRQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    state[0] && cfg_wr && live |=> !state[1]); // R4
  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !state[1] |-> !pin_hiz && !pin_freeze); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !state[0] |-> !hold_ack); // R6
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    state[1] && !rst_req && live |=> state[0] && wake_stb && run_bit); // R7
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |=> !wake_stb); // R7
  AST_LVL7_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    state[1] && !rst_req && !live |=> state[1]); // R8
  AST_RST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    state[1] && rst_req |=> state[2] && !wake_stb); // R11
  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state[2] && !osc_ok |=> state[2]); // R10
  AST_RUN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    state[0] && rst_req |=> state[3]); // R12
  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state)); // R1
endmodule

bind wmode_ctrl wmode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_run(cfg_run),
  .on_subclk(on_subclk), .irq_req(irq_req), .irq_lvl(irq_lvl),
  .rst_req(rst_req), .osc_ok(osc_ok), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .wtmr_en(wtmr_en), .pin_hiz(pin_hiz),
  .pin_freeze(pin_freeze), .hold_ack(hold_ack), .wake_stb(wake_stb),
  .run_bit(run_bit), .state(state)
);

// File: tb/sim_wmode_ctrl.sv
module sim_wmode_ctrl;
  localparam int WAIT_LEN = 8;
  localparam int NV = 9;
  // input field order: wr run float subclk irq lvl[2:0] rst hold osc
  localparam logic [10:0] IDLE = 11'b0_0_0_1_0_000_0_0_1;
  // expected field order: state[3:0] cpu wtmr hiz freeze hack wake run
  localparam logic [21:0] VEC [NV] = '{
    {11'b0_0_0_0_0_000_0_1_1, 11'b0001_1_1_0_0_1_0_1},
    {11'b1_0_0_0_0_000_0_0_1, 11'b0001_1_1_0_0_0_0_0},
    {11'b1_0_0_1_1_010_0_0_1, 11'b0001_1_1_0_0_0_0_0},
    {11'b1_0_1_1_0_000_0_0_1, 11'b0010_0_1_1_0_0_0_0},
    {11'b0_0_0_1_1_111_0_1_1, 11'b0010_0_1_1_0_0_0_0},
    {11'b0_0_0_1_1_011_0_0_1, 11'b0001_1_1_0_0_0_1_1},
    {11'b0_0_0_1_0_000_0_0_1, 11'b0001_1_1_0_0_0_0_1},
    {11'b1_0_0_1_0_000_0_0_1, 11'b0010_0_1_0_1_0_0_0},
    {11'b0_0_0_1_1_000_1_0_1, 11'b0100_0_0_0_0_0_0_0}
  };
  localparam string TAG [NV] = '{"R6", "R3", "R4", "R2 R5", "R8 R6",
                                 "R7", "R7", "R5", "R11"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, run = 0, flt = 0, sc = 0, irq = 0, rs = 0, hold = 0, osc = 1;
  logic [2:0] lvl = 3'b000;
  logic cpu, per, wt, hiz, frz, hak, wk, rb;
  logic [3:0] st;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wmode_ctrl #(.WAIT_LEN(WAIT_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_run(run), .cfg_float(flt),
    .on_subclk(sc), .irq_req(irq), .irq_lvl(lvl), .rst_req(rs),
    .hold_req(hold), .osc_ok(osc), .cpu_clk_en(cpu), .per_clk_en(per),
    .wtmr_en(wt), .pin_hiz(hiz), .pin_freeze(frz), .hold_ack(hak),
    .wake_stb(wk), .run_bit(rb), .state(st));

  wire [10:0] obs = {st, cpu, wt, hiz, frz, hak, wk, rb};

  task automatic chk(input string tag, input logic [10:0] got, input logic [10:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [10:0] v);
    {wr, run, flt, sc, irq, lvl, rs, hold, osc} = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset", obs, 11'b0001_1_1_0_0_0_0_1);
    chk("R1 per_clk_en", {10'd0, per}, 11'd1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:11]);
      chk(TAG[i], obs, VEC[i][10:0]);
    end

    // R9: wait length counted from the edge that entered the wait
    for (int i = 1; i < WAIT_LEN; i++) begin
      drive(IDLE);
      chk("R9 wait", {7'd0, st}, {7'd0, 4'b0100});
    end
    drive(IDLE);
    chk("R9 reset seq", obs, 11'b1000_1_0_0_0_0_0_0);
    drive(IDLE);
    chk("R9 back to run", obs, 11'b0001_1_1_0_0_0_0_1);

    // R2: write of run=1 on sub-clock stays in run
    drive(11'b1_1_0_1_0_000_0_0_1);
    chk("R2 run=1 write", obs, 11'b0001_1_1_0_0_0_0_1);

    // R10: oscillator not stable holds the wait
    drive(11'b1_0_0_1_0_000_0_0_1);
    chk("R10 enter watch", {7'd0, st}, {7'd0, 4'b0010});
    drive(11'b0_0_0_1_0_000_1_0_0);
    chk("R10 wait entry", {7'd0, st}, {7'd0, 4'b0100});
    for (int i = 0; i < WAIT_LEN + 4; i++) begin
      drive(11'b0_0_0_1_0_000_0_0_0);
      chk("R10 held", {7'd0, st}, {7'd0, 4'b0100});
    end
    drive(IDLE);
    chk("R10 release", {7'd0, st}, {7'd0, 4'b1000});
    drive(IDLE);
    chk("R10 run", {7'd0, st}, {7'd0, 4'b0001});

    // R12: reset request in run
    drive(11'b0_0_0_1_0_000_1_0_1);
    chk("R12 run reset", {7'd0, st}, {7'd0, 4'b1000});
    drive(IDLE);
    chk("R12 return", obs, 11'b0001_1_1_0_0_0_0_1);

    // R7: interrupt held for two cycles gives a single strobe
    drive(11'b1_0_1_1_0_000_0_0_1);
    drive(11'b0_0_0_1_1_000_0_0_1);
    chk("R7 wake", obs, 11'b0001_1_1_0_0_0_1_1);
    drive(11'b0_0_0_1_1_000_0_0_1);
    chk("R7 single pulse", obs, 11'b0001_1_1_0_0_0_0_1);

    finish_run();
  end
endmodule